// File: doc/BRIEF.md
# PCM Time-Slot Interface

This block moves 8-bit voice samples for two channels between a core and a time-division-multiplexed PCM highway that has two ports, A and B. A one-cycle frame-sync pulse starts each frame, and the frame is then counted as a run of 8-bit slots. Each channel has four programmable settings: its own transmit slot, its own receive slot, and for each direction the port it uses. In its transmit slot a channel shifts its sample out, most significant bit first. The sample is the byte that was present on its transmit input when the frame began. In its receive slot it shifts in a byte from the chosen receive line. The finished byte is handed to the core with a one-cycle valid pulse and a channel tag.

The design runs entirely on the PCM bit clock. A transmit output and its drive enable change only on the rising edge. Receive lines are sampled on the falling edge. Outside a burst, and whenever the enable input is low, the drive enables are low, so the pad cells hold the highway lines at high impedance. Each port also has a slot strobe. The strobe tells an open-drain pad to pull its line low while that port is carrying transmit data; at all other times the line is released.

Framing is a three-state machine:
- **IDLE** is entered from reset and from any state when enable is low.
- **RUN** is entered from any state when frame sync is sampled high with enable high. This is the restart transition. While in RUN, the bit counter advances once per cycle.
- **GAP** is entered from RUN when the last bit of the frame has been counted and no new sync is present. This is the frame-end transition. GAP waits there for the next sync.

Top module: `pcm_tsi`

## Requirements
- R1: When frame sync is high at a rising edge with enable high, the cycle that follows is bit 0 of slot 0. The k-th cycle after that edge is bit k mod 8 of slot k/8. A sync that arrives in the middle of a frame restarts the count in the same way.
- R2: After BITS_PER_FRAME counted cycles with no new sync, the block enters GAP. No transmit enable, strobe or receive capture occurs until the next sync.
- R3: In its transmit slot, a channel drives the port it selects (select value 0 means port A, 1 means port B). It sends its byte most significant bit first, one bit per cycle for 8 cycles, with that port's drive enable high throughout.
- R4: The transmit byte of each channel is captured at the edge that samples frame sync. Later changes to the transmit input have no effect on the frame in progress.
- R5: The strobe output of a port is high (pull low) in exactly the cycles in which that port's drive enable is high.
- R6: If both channels select the same transmit slot on the same port, channel 1's bits are driven and channel 2 is silent. If they select the same slot on different ports, both ports drive.
- R7: A slot number greater than or equal to BITS_PER_FRAME/8 disables that channel's transmit or receive direction.
- R8: While enable is low, both drive enables, both strobes and the receive valid stay low, even when frame sync pulses.
- R9: In each of the 8 cycles of a channel's receive slot, the selected receive line is sampled on the falling edge, most significant bit first. In the cycle after the eighth bit, rx_valid is high for one cycle, rx_byte holds the byte, and rx_chan is 0 for channel 1 or 1 for channel 2.
- R10: If both channels finish a receive byte in the same cycle, channel 1 is presented first and channel 2 in the next cycle.
- R11: After reset, both drive enables, both strobes and rx_valid are low, and the block stays idle until a frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Active mode; low forces the inactive state |
| fsync | input | 1 | Frame sync pulse, synchronous to clk |
| c1_tx_slot | input | SLOT_W | Channel 1 transmit slot |
| c2_tx_slot | input | SLOT_W | Channel 2 transmit slot |
| c1_rx_slot | input | SLOT_W | Channel 1 receive slot |
| c2_rx_slot | input | SLOT_W | Channel 2 receive slot |
| c1_tx_on_b | input | 1 | Channel 1 transmit port (0 A, 1 B) |
| c2_tx_on_b | input | 1 | Channel 2 transmit port (0 A, 1 B) |
| c1_rx_on_b | input | 1 | Channel 1 receive port (0 A, 1 B) |
| c2_rx_on_b | input | 1 | Channel 2 receive port (0 A, 1 B) |
| c1_tx_byte | input | 8 | Channel 1 sample to send |
| c2_tx_byte | input | 8 | Channel 2 sample to send |
| hwy_a_rx | input | 1 | Port A receive line |
| hwy_b_rx | input | 1 | Port B receive line |
| hwy_a_tx | output | 1 | Port A transmit data |
| hwy_a_tx_en | output | 1 | Port A drive enable (low means high impedance) |
| hwy_b_tx | output | 1 | Port B transmit data |
| hwy_b_tx_en | output | 1 | Port B drive enable (low means high impedance) |
| slot_strobe_a | output | 1 | Port A open-drain strobe, 1 pulls the line low |
| slot_strobe_b | output | 1 | Port B open-drain strobe, 1 pulls the line low |
| rx_byte | output | 8 | Received sample |
| rx_valid | output | 1 | One-cycle pulse marking rx_byte valid |
| rx_chan | output | 1 | Channel of rx_byte (0 channel 1, 1 channel 2) |

## Verification
The assertions assume the following about the inputs:
- frame sync is a single-cycle pulse that changes only just after a rising edge;
- the slot and port settings are held steady for a whole frame;
- each channel's receive slots stay at least two cycles apart, so a deferred channel-2 byte is never overtaken.

The stimulus keeps to these assumptions. It changes every input two nanoseconds after a rising edge, reprograms the settings only between frames, and gives each frame BITS_PER_FRAME plus two cycles. The last two of those cycles let the frame-end transition and any deferred byte be seen before the next sync. On each receive line the stimulus drives a different byte in every slot, so a wrong slot or a wrong port selection shows up as wrong data.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
    localparam int BYTE_W = 8;
    localparam int NCH    = 2;
    localparam int NPORT  = 2;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_GAP  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/pcm_tsi_framer.sv
module pcm_tsi_framer
    import pcm_tsi_pkg::*;
#(
    parameter int BITS_PER_FRAME = 32,
    parameter int CNT_W          = $clog2(BITS_PER_FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fsync,
    output logic             run,
    output logic             frame_start,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_FRAME - 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = FR_IDLE;
            cnt_d   = '0;
        end else if (fsync) begin
            state_d = FR_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FR_IDLE: state_d = FR_IDLE;
                FR_RUN: begin
                    if (cnt_q == LAST) begin
                        state_d = FR_GAP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                FR_GAP:  state_d = FR_GAP;
                default: state_d = FR_IDLE;
            endcase
        end
    end

    always_comb begin
        run         = (state_q == FR_RUN);
        cnt         = cnt_q;
        frame_start = enable && fsync;
    end

    // R1
    frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fsync) |=> (run && cnt == '0));

    // R1
    bit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enable && !fsync && cnt != LAST) |=> (run && cnt == $past(cnt) + 1'b1));

    // R2
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fsync && cnt == LAST) |=> !run);
endmodule

// File: rtl/pcm_tsi_tx.sv
module pcm_tsi_tx
    import pcm_tsi_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int CNT_W  = 5,
    parameter int NSLOTS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic [CNT_W-1:0]               cnt,
    input  logic [NCH-1:0][SLOT_W-1:0]     tx_slot,
    input  logic [NCH-1:0]                 tx_on_b,
    input  logic [NCH-1:0][BYTE_W-1:0]     tx_hold,
    output logic [NPORT-1:0]               dx,
    output logic [NPORT-1:0]               dx_en
);
    localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NSLOTS);

    logic [SLOT_W-1:0] cur_slot;
    logic [2:0]        bit_pos;
    logic [NCH-1:0]    in_slot;
    logic [NCH-1:0]    cur_bit;

    assign cur_slot = SLOT_W'(cnt[CNT_W-1:3]);
    assign bit_pos  = 3'd7 - cnt[2:0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign in_slot[c] = run && ({1'b0, tx_slot[c]} < SLOT_LIMIT)
                            && (tx_slot[c] == cur_slot);
        assign cur_bit[c] = tx_hold[c][bit_pos];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic own1, own2;
        assign own1     = in_slot[0] && (tx_on_b[0] == 1'(p));
        assign own2     = in_slot[1] && (tx_on_b[1] == 1'(p)) && !own1;
        assign dx_en[p] = own1 || own2;
        assign dx[p]    = own1 ? cur_bit[0] : (own2 ? cur_bit[1] : 1'b0);
    end

    // R8
    quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (dx_en == '0));
endmodule

// File: rtl/pcm_tsi_rx.sv
module pcm_tsi_rx
    import pcm_tsi_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int CNT_W  = 5,
    parameter int NSLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NPORT-1:0]           dr,
    input  logic [NCH-1:0][SLOT_W-1:0] rx_slot,
    input  logic [NCH-1:0]             rx_on_b,
    output logic [BYTE_W-1:0]          rx_byte,
    output logic                       rx_valid,
    output logic                       rx_chan
);
    localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NSLOTS);

    logic [NPORT-1:0]              dr_q;
    logic [SLOT_W-1:0]             cur_slot;
    logic [NCH-1:0]                done;
    logic [NCH-1:0][BYTE_W-1:0]    next_byte;
    logic                          pend_q;
    logic [BYTE_W-1:0]             pend_byte_q;

    assign cur_slot = SLOT_W'(cnt[CNT_W-1:3]);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) dr_q <= '0;
        else        dr_q <= dr;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [BYTE_W-1:0] sh_q;
        logic              in_slot;
        assign in_slot      = run && ({1'b0, rx_slot[c]} < SLOT_LIMIT)
                              && (rx_slot[c] == cur_slot);
        assign next_byte[c] = {sh_q[BYTE_W-2:0], dr_q[rx_on_b[c]]};
        assign done[c]      = in_slot && (cnt[2:0] == 3'd7);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (in_slot) sh_q <= next_byte[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid    <= 1'b0;
            rx_chan     <= 1'b0;
            rx_byte     <= '0;
            pend_q      <= 1'b0;
            pend_byte_q <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (done[0]) begin
                rx_valid <= 1'b1;
                rx_chan  <= 1'b0;
                rx_byte  <= next_byte[0];
                if (done[1]) begin
                    pend_q      <= 1'b1;
                    pend_byte_q <= next_byte[1];
                end
            end else if (pend_q) begin
                rx_valid <= 1'b1;
                rx_chan  <= 1'b1;
                rx_byte  <= pend_byte_q;
                pend_q   <= done[1];
                if (done[1]) pend_byte_q <= next_byte[1];
            end else if (done[1]) begin
                rx_valid <= 1'b1;
                rx_chan  <= 1'b1;
                rx_byte  <= next_byte[1];
            end
        end
    end

    // R9
    rx_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_chan) |-> ($past(run) && $past(cnt[2:0]) == 3'd7));

    // R10
    rx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (!rx_valid || (rx_chan && !$past(rx_chan))));
endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int BITS_PER_FRAME = 32,
    parameter int SLOT_W         = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] c1_tx_slot,
    input  logic [SLOT_W-1:0] c2_tx_slot,
    input  logic [SLOT_W-1:0] c1_rx_slot,
    input  logic [SLOT_W-1:0] c2_rx_slot,
    input  logic              c1_tx_on_b,
    input  logic              c2_tx_on_b,
    input  logic              c1_rx_on_b,
    input  logic              c2_rx_on_b,
    input  logic [7:0]        c1_tx_byte,
    input  logic [7:0]        c2_tx_byte,
    input  logic              hwy_a_rx,
    input  logic              hwy_b_rx,
    output logic              hwy_a_tx,
    output logic              hwy_a_tx_en,
    output logic              hwy_b_tx,
    output logic              hwy_b_tx_en,
    output logic              slot_strobe_a,
    output logic              slot_strobe_b,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    output logic              rx_chan
);
    localparam int CNT_W  = $clog2(BITS_PER_FRAME);
    localparam int NSLOTS = BITS_PER_FRAME / 8;

    logic                       run, frame_start;
    logic [CNT_W-1:0]           cnt;
    logic [NCH-1:0][BYTE_W-1:0] tx_hold_q;
    logic [NPORT-1:0]           dx, dx_en, drive;

    pcm_tsi_framer #(.BITS_PER_FRAME(BITS_PER_FRAME), .CNT_W(CNT_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fsync(fsync),
        .run(run), .frame_start(frame_start), .cnt(cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tx_hold_q <= '0;
        else if (frame_start) tx_hold_q <= {c2_tx_byte, c1_tx_byte};
    end

    pcm_tsi_tx #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .NSLOTS(NSLOTS)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .tx_slot({c2_tx_slot, c1_tx_slot}),
        .tx_on_b({c2_tx_on_b, c1_tx_on_b}),
        .tx_hold(tx_hold_q),
        .dx(dx), .dx_en(dx_en)
    );

    pcm_tsi_rx #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .NSLOTS(NSLOTS)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .dr({hwy_b_rx, hwy_a_rx}),
        .rx_slot({c2_rx_slot, c1_rx_slot}),
        .rx_on_b({c2_rx_on_b, c1_rx_on_b}),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_chan(rx_chan)
    );

    assign drive         = dx_en & {NPORT{enable}};
    assign hwy_a_tx      = dx[0];
    assign hwy_b_tx      = dx[1];
    assign hwy_a_tx_en   = drive[0];
    assign hwy_b_tx_en   = drive[1];
    assign slot_strobe_a = drive[0];
    assign slot_strobe_b = drive[1];

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && !run));
endmodule

// File: tb/pcm_tsi_bench.sv
module pcm_tsi_bench;
    localparam int BITS   = 32;
    localparam int NS     = BITS / 8;
    localparam int SLOT_W = 7;
    localparam int NVEC   = 6;

    // {t1, t2, r1, r2, t1_on_b, t2_on_b, r1_on_b, r2_on_b, d1, d2}
    localparam logic [47:0] VECS [0:NVEC-1] = '{
        {7'd0, 7'd1,   7'd2, 7'd3,   4'b0000, 8'hA5, 8'h3C},
        {7'd3, 7'd0,   7'd0, 7'd1,   4'b1010, 8'h5A, 8'hC3},
        {7'd2, 7'd2,   7'd1, 7'd1,   4'b0011, 8'hF0, 8'h0F},
        {7'd1, 7'd1,   7'd3, 7'd3,   4'b0101, 8'h81, 8'h7E},
        {7'd4, 7'd127, 7'd4, 7'd9,   4'b1111, 8'hFF, 8'hFF},
        {7'd3, 7'd5,   7'd0, 7'd127, 4'b0000, 8'hC9, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic fsync = 1'b0;
    logic [SLOT_W-1:0] t1 = '0, t2 = '0, r1 = '0, r2 = '0;
    logic tb1 = 1'b0, tb2 = 1'b0, rb1 = 1'b0, rb2 = 1'b0;
    logic [7:0] d1 = '0, d2 = '0;
    logic dra = 1'b0, drb = 1'b0;
    logic dxa, dxa_en, dxb, dxb_en, sta, stb;
    logic [7:0] rx_byte;
    logic rx_valid, rx_chan;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pcm_tsi #(.BITS_PER_FRAME(BITS), .SLOT_W(SLOT_W)) u_pcm_tsi (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fsync(fsync),
        .c1_tx_slot(t1), .c2_tx_slot(t2), .c1_rx_slot(r1), .c2_rx_slot(r2),
        .c1_tx_on_b(tb1), .c2_tx_on_b(tb2), .c1_rx_on_b(rb1), .c2_rx_on_b(rb2),
        .c1_tx_byte(d1), .c2_tx_byte(d2),
        .hwy_a_rx(dra), .hwy_b_rx(drb),
        .hwy_a_tx(dxa), .hwy_a_tx_en(dxa_en), .hwy_b_tx(dxb), .hwy_b_tx_en(dxb_en),
        .slot_strobe_a(sta), .slot_strobe_b(stb),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_chan(rx_chan)
    );

    function automatic logic [7:0] line_a(int s);
        return 8'h96 ^ 8'(s * 29);
    endfunction

    function automatic logic [7:0] line_b(int s);
        return 8'h3B + 8'(s * 71);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load_vec(int vi);
        logic [47:0] v;
        v = VECS[vi];
        t1 = v[47:41]; t2 = v[40:34]; r1 = v[33:27]; r2 = v[26:20];
        tb1 = v[19]; tb2 = v[18]; rb1 = v[17]; rb2 = v[16];
        d1 = v[15:8]; d2 = v[7:0];
    endtask

    // Called at posedge+2; pulses sync, then walks BITS+2 cycles.
    task automatic run_frame(bit act, string ttag, string rtag);
        bit e_t1, e_t2, e_r1, e_r2;
        e_t1 = act && (int'(t1) < NS);
        e_t2 = act && (int'(t2) < NS);
        e_r1 = act && (int'(r1) < NS);
        e_r2 = act && (int'(r2) < NS);
        fsync = 1'b1;
        @(posedge clk); #2;
        fsync = 1'b0;
        for (int k = 0; k < BITS + 2; k++) begin
            int  slot, bp, r2_at;
            bit  running, h1a, h1b, h2a, h2b, ev1, ev2;
            string tt;
            slot    = k / 8;
            bp      = 7 - (k % 8);
            running = (k < BITS);
            dra = (act && running) ? line_a(slot)[bp] : 1'b0;
            drb = (act && running) ? line_b(slot)[bp] : 1'b0;
            #10;
            tt  = running ? ttag : "R2";
            h1a = running && e_t1 && !tb1 && int'(t1) == slot;
            h1b = running && e_t1 &&  tb1 && int'(t1) == slot;
            h2a = running && e_t2 && !tb2 && int'(t2) == slot && !h1a;
            h2b = running && e_t2 &&  tb2 && int'(t2) == slot && !h1b;
            chk(tt, 32'(dxa_en), 32'(h1a || h2a));
            chk(tt, 32'(dxb_en), 32'(h1b || h2b));
            chk("R5", 32'({sta, stb}), 32'({h1a || h2a, h1b || h2b}));
            if (h1a || h2a) chk(tt, 32'(dxa), 32'(h1a ? d1[bp] : d2[bp]));
            if (h1b || h2b) chk(tt, 32'(dxb), 32'(h1b ? d1[bp] : d2[bp]));
            r2_at = (e_r1 && r1 == r2) ? 8 * int'(r2) + 9 : 8 * int'(r2) + 8;
            ev1 = e_r1 && k == 8 * int'(r1) + 8;
            ev2 = e_r2 && k == r2_at;
            chk(rtag, 32'(rx_valid), 32'(ev1 || ev2));
            if (ev1) chk(rtag, 32'({rx_chan, rx_byte}),
                         32'({1'b0, rb1 ? line_b(int'(r1)) : line_a(int'(r1))}));
            if (ev2) chk(rtag, 32'({rx_chan, rx_byte}),
                         32'({1'b1, rb2 ? line_b(int'(r2)) : line_a(int'(r2))}));
            @(posedge clk); #2;
        end
    endtask

    initial begin
        #(20 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        #15;
        chk("R11", 32'({dxa_en, dxb_en, sta, stb, rx_valid}), 32'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        enable = 1'b1;
        load_vec(0);
        repeat (3) @(posedge clk);
        #2;
        chk("R11", 32'({dxa_en, dxb_en, sta, stb, rx_valid}), 32'd0);

        // Table walk: R3 R9 basic, R6 R10 collisions, R7 disabled slots
        for (int vi = 0; vi < NVEC; vi++) begin
            load_vec(vi);
            if (vi == 2 || vi == 3)      run_frame(1'b1, "R6", "R10");
            else if (vi == 4 || vi == 5) run_frame(1'b1, "R7", "R7");
            else                         run_frame(1'b1, "R3", "R9");
        end

        // R8: inactive mode ignores sync
        enable = 1'b0;
        load_vec(0);
        run_frame(1'b0, "R8", "R8");
        enable = 1'b1;
        @(posedge clk); #2;

        // R4 and R1: late byte change ignored, mid-frame sync restarts
        load_vec(0);
        d1 = 8'hA5;
        fsync = 1'b1;
        @(posedge clk); #2;
        fsync = 1'b0;
        d1 = 8'h5A;
        #10;
        chk("R1", 32'({dxa_en, dxa}), 32'({1'b1, 1'b1}));
        @(posedge clk); #12;
        chk("R4", 32'({dxa_en, dxa}), 32'({1'b1, 1'b0}));
        @(posedge clk); #2;
        fsync = 1'b1;
        #10;
        chk("R4", 32'({dxa_en, dxa}), 32'({1'b1, 1'b1}));
        @(posedge clk); #2;
        fsync = 1'b0;
        #10;
        chk("R1", 32'({dxa_en, dxa}), 32'({1'b1, 1'b0}));
        @(posedge clk); #12;
        chk("R1", 32'({dxa_en, dxa}), 32'({1'b1, 1'b1}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule